// File: doc/BRIEF.md
# Bidirectional dual-clock FIFO pair

This block sits between two independently clocked ports, A and B, and moves 32-bit words in both directions through two separate asynchronous FIFOs. FIFO1 carries words from port A to port B and FIFO2 carries words from port B to port A. Each port has an active-low select, a direction bit, a mailbox-select bit and a transfer enable. From these the port decides on each rising edge of its own clock whether it pushes a word into one FIFO or pops a word from the other.

Each port has one active-low ready pin. The port's direction bit chooses what that pin reports. When the port is set to write, the pin shows room in the FIFO it writes. When the port is set to read, the pin shows a stored word in the FIFO it reads. The pin follows the direction bit combinationally.

Each FIFO also drives an almost-empty flag on its reading port, timed by the reading clock. The flag is high only while the count of words not yet read is above a per-FIFO offset. Pointers cross between the clock domains in Gray code through two-flop synchronizers. The depth and both offsets are parameters.

Top module: `bidir_fifo_pair`

## Requirements
- R1: With a_sel_n=0, a_dir=1, a_mbx=0 and a_en=1 at a rising clk_a, a_din is written into FIFO1. With b_sel_n=0, b_dir=1, b_mbx=0 and b_en=1 at a rising clk_b, the oldest FIFO1 word is loaded into b_dout, which holds it after that edge. Words leave in the order they entered.
- R2: With b_sel_n=0, b_dir=0, b_mbx=0 and b_en=1 at a rising clk_b, b_din is written into FIFO2. With a_sel_n=0, a_dir=0, a_mbx=0 and a_en=1 at a rising clk_a, the oldest FIFO2 word is loaded into a_dout. Words leave in order.
- R3: A port edge with the select high, the mailbox bit high or the enable low moves no word. After such edges the FIFO the port would have served still reports the same fill state on its ready and almost-empty pins.
- R4: a_rdy is low when a_dir=1 and FIFO1 is not full. a_rdy is low when a_dir=0 and FIFO2 holds an unread word. Otherwise a_rdy is high. A change of a_dir changes a_rdy without a clock edge.
- R5: b_rdy is low when b_dir=1 and FIFO1 holds an unread word. b_rdy is low when b_dir=0 and FIFO2 is not full. Otherwise b_rdy is high. It follows b_dir without a clock edge.
- R6: While a FIFO holds DEPTH unread words, a write into it is dropped. Exactly DEPTH words then come out, and the writing port's ready pin stays high until a read makes room.
- R7: A read of an empty FIFO leaves the reading port's data output unchanged.
- R8: b_ae_n is high when more than AE_OFFSET_1 unread FIFO1 words are stored, and low otherwise. It rises on the second rising clk_b edge after the clk_a write that takes the count from AE_OFFSET_1 to AE_OFFSET_1+1. It falls right after the clk_b read that brings the count back down to AE_OFFSET_1. A word already read out into b_dout is not counted.
- R9: a_ae_n behaves the same way for FIFO2, with AE_OFFSET_2, clk_a as the reading clock and clk_b as the writing clock.
- R10: While rst_n is low, both FIFOs are empty, both data outputs are 0 and both almost-empty flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_n | input | 1 | Asynchronous active-low reset for both FIFOs |
| a_sel_n | input | 1 | Port A select, active low |
| a_dir | input | 1 | Port A direction: 1 writes FIFO1, 0 reads FIFO2 |
| a_mbx | input | 1 | Port A mailbox select; when 1, no FIFO is touched |
| a_en | input | 1 | Port A transfer enable |
| a_din | input | WIDTH | Word written into FIFO1 |
| a_dout | output | WIDTH | Last word read from FIFO2 |
| a_rdy | output | 1 | Port A ready, active low, chosen by a_dir |
| a_ae_n | output | 1 | FIFO2 almost-empty flag, low while almost empty |
| b_sel_n | input | 1 | Port B select, active low |
| b_dir | input | 1 | Port B direction: 1 reads FIFO1, 0 writes FIFO2 |
| b_mbx | input | 1 | Port B mailbox select; when 1, no FIFO is touched |
| b_en | input | 1 | Port B transfer enable |
| b_din | input | WIDTH | Word written into FIFO2 |
| b_dout | output | WIDTH | Last word read from FIFO1 |
| b_rdy | output | 1 | Port B ready, active low, chosen by b_dir |
| b_ae_n | output | 1 | FIFO1 almost-empty flag, low while almost empty |

## Verification
Short bursts in each direction show that data and ordering are correct and that the two FIFOs do not mix. Edges with one decode input wrong at a time show that each of select, mailbox bit and enable blocks a transfer by itself. A fill past DEPTH followed by a drain and one more read separates dropped writes from lost or repeated words, and shows whether an empty read disturbs the output. The almost-empty flags are sampled one and two reading-clock edges after the write that crosses the offset, and again just after the read that drops back to it, with clock B trailing clock A by a fixed phase. This separates the two-stage synchronizer timing from both a shorter and a longer path.

// File: rtl/bfp_pkg.sv
package bfp_pkg;

   // Port request pair: hi_go is the transfer selected with the direction
   // bit high, lo_go the one selected with it low.
   typedef struct packed {
      logic hi_go;
      logic lo_go;
   } bfp_req_t;

endpackage

// File: rtl/bfp_sync.sv
module bfp_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_chk_stages
      $error("bfp_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg <= '0;
      end else begin
         stg <= {stg[STAGES-2:0], d};
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/bfp_port_ctl.sv
module bfp_port_ctl
   import bfp_pkg::*;
(
   input  logic     sel_n,
   input  logic     dir,
   input  logic     mbx,
   input  logic     en,
   input  logic     stat_hi,
   input  logic     stat_lo,
   output bfp_req_t req,
   output logic     rdy
);

   logic active;

   assign active    = !sel_n && !mbx && en;
   assign req.hi_go = active && dir;
   assign req.lo_go = active && !dir;
   assign rdy       = dir ? stat_hi : stat_lo;

endmodule

// File: rtl/bfp_fifo.sv
module bfp_fifo #(
   parameter int WIDTH       = 32,
   parameter int DEPTH       = 512,
   parameter int AE_OFFSET   = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             wclk,
   input  logic             rst_n,
   input  logic             wr_req,
   input  logic [WIDTH-1:0] wdata,
   output logic             full,
   input  logic             rclk,
   input  logic             rd_req,
   output logic [WIDTH-1:0] rdata,
   output logic             empty,
   output logic             ae_n
);

   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 1;

   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_chk_depth
      $error("bfp_fifo: DEPTH must be a power of two, at least 4");
   end
   if (AE_OFFSET < 0 || AE_OFFSET >= DEPTH) begin : g_chk_offset
      $error("bfp_fifo: AE_OFFSET must lie in 0..DEPTH-1");
   end
   if (WIDTH < 1) begin : g_chk_width
      $error("bfp_fifo: WIDTH must be positive");
   end

   function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic logic [PW-1:0] to_bin(input logic [PW-1:0] g);
      logic [PW-1:0] b;
      b[PW-1] = g[PW-1];
      for (int i = PW - 2; i >= 0; i--) begin
         b[i] = b[i+1] ^ g[i];
      end
      return b;
   endfunction

   logic [WIDTH-1:0] mem [DEPTH];

   // write domain
   logic [PW-1:0] wr_bin, wr_gray, rd_gray_ws;
   logic [PW-1:0] wr_bin_nx;
   logic          we;

   assign full      = (wr_gray == {~rd_gray_ws[PW-1:PW-2], rd_gray_ws[PW-3:0]});
   assign we        = wr_req && !full;
   assign wr_bin_nx = wr_bin + PW'(1);

   always_ff @(posedge wclk or negedge rst_n) begin
      if (!rst_n) begin
         wr_bin  <= '0;
         wr_gray <= '0;
      end else if (we) begin
         wr_bin  <= wr_bin_nx;
         wr_gray <= to_gray(wr_bin_nx);
      end
   end

   always_ff @(posedge wclk) begin
      if (we) begin
         mem[wr_bin[AW-1:0]] <= wdata;
      end
   end

   // read domain
   logic [PW-1:0] rd_bin, rd_gray, wr_gray_rs, wr_bin_rs;
   logic [PW-1:0] rd_bin_nx, fill;
   logic          re;

   assign empty     = (rd_gray == wr_gray_rs);
   assign re        = rd_req && !empty;
   assign rd_bin_nx = rd_bin + PW'(1);
   assign wr_bin_rs = to_bin(wr_gray_rs);
   assign fill      = wr_bin_rs - rd_bin;

   always_ff @(posedge rclk or negedge rst_n) begin
      if (!rst_n) begin
         rd_bin  <= '0;
         rd_gray <= '0;
         rdata   <= '0;
      end else if (re) begin
         rd_bin  <= rd_bin_nx;
         rd_gray <= to_gray(rd_bin_nx);
         rdata   <= mem[rd_bin[AW-1:0]];
      end
   end

   if (AE_OFFSET == 0) begin : g_ae_zero
      assign ae_n = !empty;
   end else begin : g_ae_cmp
      assign ae_n = (fill > PW'(AE_OFFSET));
   end

   // pointer crossings
   bfp_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_rd (
      .clk   (wclk),
      .rst_n (rst_n),
      .d     (rd_gray),
      .q     (rd_gray_ws)
   );

   bfp_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_wr (
      .clk   (rclk),
      .rst_n (rst_n),
      .d     (wr_gray),
      .q     (wr_gray_rs)
   );

endmodule

// File: rtl/bidir_fifo_pair.sv
module bidir_fifo_pair
   import bfp_pkg::*;
#(
   parameter int WIDTH       = 32,
   parameter int DEPTH       = 512,
   parameter int AE_OFFSET_1 = 8,
   parameter int AE_OFFSET_2 = 8
) (
   input  logic             clk_a,
   input  logic             clk_b,
   input  logic             rst_n,
   input  logic             a_sel_n,
   input  logic             a_dir,
   input  logic             a_mbx,
   input  logic             a_en,
   input  logic [WIDTH-1:0] a_din,
   output logic [WIDTH-1:0] a_dout,
   output logic             a_rdy,
   output logic             a_ae_n,
   input  logic             b_sel_n,
   input  logic             b_dir,
   input  logic             b_mbx,
   input  logic             b_en,
   input  logic [WIDTH-1:0] b_din,
   output logic [WIDTH-1:0] b_dout,
   output logic             b_rdy,
   output logic             b_ae_n
);

   bfp_req_t req_a, req_b;
   logic     f1_full, f1_empty, f2_full, f2_empty;
   logic     f1_wr_req, f1_rd_req, f2_wr_req, f2_rd_req;

   // port A: direction high writes FIFO1, low reads FIFO2
   bfp_port_ctl u_ctl_a (
      .sel_n   (a_sel_n),
      .dir     (a_dir),
      .mbx     (a_mbx),
      .en      (a_en),
      .stat_hi (f1_full),
      .stat_lo (f2_empty),
      .req     (req_a),
      .rdy     (a_rdy)
   );

   // port B: direction high reads FIFO1, low writes FIFO2
   bfp_port_ctl u_ctl_b (
      .sel_n   (b_sel_n),
      .dir     (b_dir),
      .mbx     (b_mbx),
      .en      (b_en),
      .stat_hi (f1_empty),
      .stat_lo (f2_full),
      .req     (req_b),
      .rdy     (b_rdy)
   );

   assign f1_wr_req = req_a.hi_go;
   assign f2_rd_req = req_a.lo_go;
   assign f1_rd_req = req_b.hi_go;
   assign f2_wr_req = req_b.lo_go;

   bfp_fifo #(
      .WIDTH     (WIDTH),
      .DEPTH     (DEPTH),
      .AE_OFFSET (AE_OFFSET_1)
   ) u_fifo1 (
      .wclk   (clk_a),
      .rst_n  (rst_n),
      .wr_req (f1_wr_req),
      .wdata  (a_din),
      .full   (f1_full),
      .rclk   (clk_b),
      .rd_req (f1_rd_req),
      .rdata  (b_dout),
      .empty  (f1_empty),
      .ae_n   (b_ae_n)
   );

   bfp_fifo #(
      .WIDTH     (WIDTH),
      .DEPTH     (DEPTH),
      .AE_OFFSET (AE_OFFSET_2)
   ) u_fifo2 (
      .wclk   (clk_b),
      .rst_n  (rst_n),
      .wr_req (f2_wr_req),
      .wdata  (b_din),
      .full   (f2_full),
      .rclk   (clk_a),
      .rd_req (f2_rd_req),
      .rdata  (a_dout),
      .empty  (f2_empty),
      .ae_n   (a_ae_n)
   );

endmodule

// File: rtl/bfp_checker.sv
module bfp_checker #(
   parameter int WIDTH = 32,
   parameter int PW    = 10
) (
   input logic             clk_a,
   input logic             clk_b,
   input logic             rst_n,
   input logic             f1_wr_req,
   input logic             f1_rd_req,
   input logic             f2_wr_req,
   input logic             f2_rd_req,
   input logic             f1_full,
   input logic             f1_empty,
   input logic             f2_full,
   input logic             f2_empty,
   input logic [PW-1:0]    f1_wr_bin,
   input logic [PW-1:0]    f2_wr_bin,
   input logic [WIDTH-1:0] a_dout,
   input logic [WIDTH-1:0] b_dout,
   input logic             a_ae_n,
   input logic             b_ae_n
);

   AST_F1_NO_OVERFLOW: assert property (@(posedge clk_a) disable iff (!rst_n)
      f1_full && f1_wr_req |=> $stable(f1_wr_bin)); // R6

   AST_F2_NO_OVERFLOW: assert property (@(posedge clk_b) disable iff (!rst_n)
      f2_full && f2_wr_req |=> $stable(f2_wr_bin)); // R6

   AST_F1_NO_UNDERFLOW: assert property (@(posedge clk_b) disable iff (!rst_n)
      f1_empty && f1_rd_req |=> $stable(b_dout)); // R7

   AST_F2_NO_UNDERFLOW: assert property (@(posedge clk_a) disable iff (!rst_n)
      f2_empty && f2_rd_req |=> $stable(a_dout)); // R7

   AST_F1_AE_WHEN_EMPTY: assert property (@(posedge clk_b) disable iff (!rst_n)
      f1_empty |-> !b_ae_n); // R8

   AST_F2_AE_WHEN_EMPTY: assert property (@(posedge clk_a) disable iff (!rst_n)
      f2_empty |-> !a_ae_n); // R9

   AST_F1_WR_STEP: assert property (@(posedge clk_a) disable iff (!rst_n)
      (f1_wr_bin - $past(f1_wr_bin)) <= PW'(1)); // R1

   AST_F2_WR_STEP: assert property (@(posedge clk_b) disable iff (!rst_n)
      (f2_wr_bin - $past(f2_wr_bin)) <= PW'(1)); // R2

   AST_RESET_A: assert property (@(posedge clk_a)
      !rst_n |-> (!a_ae_n && f2_empty && a_dout == '0)); // R10

   AST_RESET_B: assert property (@(posedge clk_b)
      !rst_n |-> (!b_ae_n && f1_empty && b_dout == '0)); // R10

endmodule

bind bidir_fifo_pair bfp_checker #(
   .WIDTH (WIDTH),
   .PW    ($clog2(DEPTH) + 1)
) u_chk (
   .clk_a     (clk_a),
   .clk_b     (clk_b),
   .rst_n     (rst_n),
   .f1_wr_req (f1_wr_req),
   .f1_rd_req (f1_rd_req),
   .f2_wr_req (f2_wr_req),
   .f2_rd_req (f2_rd_req),
   .f1_full   (f1_full),
   .f1_empty  (f1_empty),
   .f2_full   (f2_full),
   .f2_empty  (f2_empty),
   .f1_wr_bin (u_fifo1.wr_bin),
   .f2_wr_bin (u_fifo2.wr_bin),
   .a_dout    (a_dout),
   .b_dout    (b_dout),
   .a_ae_n    (a_ae_n),
   .b_ae_n    (b_ae_n)
);

// File: tb/bidir_fifo_pair_tb.sv
`timescale 1ns/1ps
module bidir_fifo_pair_tb;

   localparam int WIDTH = 32;
   localparam int DEPTH = 8;
   localparam int AE1   = 2;
   localparam int AE2   = 3;

   logic clk_a, clk_b, rst_n;
   logic a_sel_n, a_dir, a_mbx, a_en, b_sel_n, b_dir, b_mbx, b_en;
   logic [WIDTH-1:0] a_din, b_din, a_dout, b_dout;
   logic a_rdy, a_ae_n, b_rdy, b_ae_n;

   int total = 0;
   int bad   = 0;
   bit done  = 0;
   logic [WIDTH-1:0] q1[$];
   logic [WIDTH-1:0] q2[$];

   bidir_fifo_pair #(
      .WIDTH(WIDTH), .DEPTH(DEPTH), .AE_OFFSET_1(AE1), .AE_OFFSET_2(AE2)
   ) u_dut (
      .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
      .a_sel_n(a_sel_n), .a_dir(a_dir), .a_mbx(a_mbx), .a_en(a_en),
      .a_din(a_din), .a_dout(a_dout), .a_rdy(a_rdy), .a_ae_n(a_ae_n),
      .b_sel_n(b_sel_n), .b_dir(b_dir), .b_mbx(b_mbx), .b_en(b_en),
      .b_din(b_din), .b_dout(b_dout), .b_rdy(b_rdy), .b_ae_n(b_ae_n)
   );

   // 125 MHz on both ports, B trailing A by 3 ns
   initial begin
      clk_a = 0;
      forever #4 clk_a = ~clk_a;
   end
   initial begin
      clk_b = 0;
      #3;
      forever #4 clk_b = ~clk_b;
   end

   task automatic chk(input string tag, input logic [WIDTH-1:0] act,
                      input logic [WIDTH-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic a_write(input logic [WIDTH-1:0] d);
      @(posedge clk_a); #1;
      a_sel_n = 0; a_dir = 1; a_mbx = 0; a_en = 1; a_din = d;
      if (q1.size() < DEPTH) q1.push_back(d);
      @(posedge clk_a); #1;
      a_en = 0; a_sel_n = 1;
   endtask

   task automatic b_write(input logic [WIDTH-1:0] d);
      @(posedge clk_b); #1;
      b_sel_n = 0; b_dir = 0; b_mbx = 0; b_en = 1; b_din = d;
      if (q2.size() < DEPTH) q2.push_back(d);
      @(posedge clk_b); #1;
      b_en = 0; b_sel_n = 1;
   endtask

   task automatic b_read();
      @(posedge clk_b); #1;
      b_sel_n = 0; b_dir = 1; b_mbx = 0; b_en = 1;
      @(posedge clk_b); #1;
      b_en = 0; b_sel_n = 1;
   endtask

   task automatic a_read();
      @(posedge clk_a); #1;
      a_sel_n = 0; a_dir = 0; a_mbx = 0; a_en = 1;
      @(posedge clk_a); #1;
      a_en = 0; a_sel_n = 1;
   endtask

   task automatic a_poke(input logic s, input logic m, input logic e);
      @(posedge clk_a); #1;
      a_sel_n = s; a_dir = 1; a_mbx = m; a_en = e; a_din = 32'hDEAD0000;
      @(posedge clk_a); #1;
      a_en = 0; a_sel_n = 1; a_mbx = 0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk_a);
      #1;
   endtask

   // monitors: pop expected word on every accepted read
   initial begin
      bit fire;
      forever begin
         @(negedge clk_b);
         fire = !b_sel_n && b_dir && !b_mbx && b_en && !b_rdy;
         @(posedge clk_b); #2;
         if (fire) begin
            if (q1.size() == 0) chk("R1 unexpected FIFO1 read", b_dout, 'x);
            else chk("R1 FIFO1 data order", b_dout, q1.pop_front());
         end
      end
   end

   initial begin
      bit fire;
      forever begin
         @(negedge clk_a);
         fire = !a_sel_n && !a_dir && !a_mbx && a_en && !a_rdy;
         @(posedge clk_a); #2;
         if (fire) begin
            if (q2.size() == 0) chk("R2 unexpected FIFO2 read", a_dout, 'x);
            else chk("R2 FIFO2 data order", a_dout, q2.pop_front());
         end
      end
   end

   initial begin
      #200000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [WIDTH-1:0] hold;
      a_sel_n = 1; a_dir = 1; a_mbx = 0; a_en = 0; a_din = '0;
      b_sel_n = 1; b_dir = 1; b_mbx = 0; b_en = 0; b_din = '0;
      rst_n = 1;
      #1 rst_n = 0;
      repeat (3) @(posedge clk_a);
      #1;
      // R10 reset state
      chk("R10 a_ae_n", a_ae_n, 0);
      chk("R10 b_ae_n", b_ae_n, 0);
      chk("R10 a_dout", a_dout, 0);
      chk("R10 b_dout", b_dout, 0);
      chk("R10 b_rdy FIFO1 empty", b_rdy, 1);
      chk("R10 a_rdy FIFO1 has room", a_rdy, 0);
      rst_n = 1;
      idle(2);

      // R1 burst A to B
      for (int i = 0; i < 5; i++) a_write(32'h1000_0000 + i);
      idle(6);
      for (int i = 0; i < 5; i++) b_read();
      idle(4);
      chk("R1 FIFO1 drained", q1.size(), 0);
      chk("R1 b_rdy empty after drain", b_rdy, 1);

      // R3 ignored decodes
      a_poke(1, 0, 1);
      a_poke(0, 1, 1);
      a_poke(0, 0, 0);
      idle(6);
      b_dir = 1; #1;
      chk("R3 FIFO1 still empty", b_rdy, 1);
      chk("R3 b_ae_n still low", b_ae_n, 0);

      // R2 burst B to A
      for (int i = 0; i < 4; i++) b_write(32'h2000_0000 + i);
      idle(6);
      for (int i = 0; i < 4; i++) a_read();
      idle(4);
      chk("R2 FIFO2 drained", q2.size(), 0);

      // R6 fill FIFO1 past depth
      for (int i = 0; i < DEPTH + 1; i++) a_write(32'h3000_0000 + i);
      b_write(32'h4000_0000);
      b_write(32'h4000_0001);
      idle(6);
      a_dir = 1; #1;
      chk("R6 a_rdy high when FIFO1 full", a_rdy, 1);
      chk("R4 a_rdy dir=1 full", a_rdy, 1);
      a_dir = 0; #1;
      chk("R4 a_rdy dir=0 FIFO2 holds words", a_rdy, 0);
      a_dir = 1; #1;
      chk("R4 a_rdy back to dir=1", a_rdy, 1);
      for (int i = 0; i < DEPTH; i++) b_read();
      idle(6);
      chk("R6 exactly DEPTH words out", q1.size(), 0);
      chk("R6 last word", b_dout, 32'h3000_0000 + DEPTH - 1);
      a_dir = 1; #1;
      chk("R6 a_rdy low after drain", a_rdy, 0);
      // R7 read while empty
      hold = b_dout;
      b_read();
      idle(2);
      chk("R7 b_dout held on empty read", b_dout, hold);
      // R5 mux
      b_dir = 1; #1;
      chk("R5 b_rdy dir=1 FIFO1 empty", b_rdy, 1);
      b_dir = 0; #1;
      chk("R5 b_rdy dir=0 FIFO2 room", b_rdy, 0);
      for (int i = 0; i < 2; i++) a_read();
      idle(4);
      hold = a_dout;
      a_read();
      idle(2);
      chk("R7 a_dout held on empty read", a_dout, hold);

      // R8 FIFO1 almost-empty timing
      for (int i = 0; i < AE1; i++) a_write(32'h5000_0000 + i);
      idle(6);
      chk("R8 count equals offset", b_ae_n, 0);
      a_write(32'h5000_00FF);
      @(posedge clk_b); #1;
      chk("R8 first clk_b edge still low", b_ae_n, 0);
      @(posedge clk_b); #1;
      chk("R8 second clk_b edge high", b_ae_n, 1);
      b_read();
      chk("R8 low right after read", b_ae_n, 0);
      for (int i = 0; i < AE1; i++) b_read();
      idle(4);

      // R9 FIFO2 almost-empty timing
      for (int i = 0; i < AE2; i++) b_write(32'h6000_0000 + i);
      idle(6);
      chk("R9 count equals offset", a_ae_n, 0);
      b_write(32'h6000_00FF);
      @(posedge clk_a); #1;
      chk("R9 first clk_a edge still low", a_ae_n, 0);
      @(posedge clk_a); #1;
      chk("R9 second clk_a edge high", a_ae_n, 1);
      a_read();
      chk("R9 low right after read", a_ae_n, 0);
      for (int i = 0; i < AE2; i++) a_read();
      idle(4);
      chk("R2 FIFO2 empty at end", q2.size(), 0);
      chk("R1 FIFO1 empty at end", q1.size(), 0);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule